// File: doc/BRIEF.md
# SPI Master with Buffer DMA

This block is an SPI master that moves bytes straight between memory and the serial lines. Software programs a transmit buffer (pointer plus maximum byte count) and a receive buffer (pointer plus maximum byte count). It then pulses one-shot tasks through a small word-addressed register port. Transmit bytes are fetched over a read port that returns data one cycle after the request. Received bytes are stored over a write port.

A transaction lasts as many bytes as the larger of the two counts. When the transmit side runs out, a programmable fill byte is shifted out. Received bytes beyond the receive count are dropped. Each milestone raises a one-cycle event that sets a sticky flag, and any flag whose enable bit is set drives the interrupt line. A chaining bit lets the completion event restart the next transaction with no software action.

The register map uses word addresses 0 to 14:
- 0: start task
- 1: stop task
- 2: suspend task
- 3: resume task
- 4: flags
- 5: interrupt enable
- 6: chaining bit
- 7: clock divider exponent
- 8: transmit pointer
- 9: transmit maximum count
- 10: transmit amount (read-only)
- 11: receive pointer
- 12: receive maximum count
- 13: receive amount (read-only)
- 14: fill byte

Flag and enable bits are:
- bit 0: begun
- bit 1: halted
- bit 2: transmit done
- bit 3: receive done
- bit 4: both done

Top module: `spim_dma_top`

## Requirements
- R1: Writing a word with bit 0 set to address 0, 1, 2 or 3 fires the start, stop, suspend or resume task once. A write with bit 0 clear has no effect.
- R2: For byte index i below the transmit count, the byte at transmit pointer + i is read from memory and shifted out MSB first in SPI mode 0. SCK idles low, MOSI changes only on falling edges, and MISO is sampled on rising edges.
- R3: For byte indices at or above the transmit count, the fill byte (address 14) is shifted out and no memory read is issued.
- R4: For byte index i below the receive count, the received byte is written to receive pointer + i. Bytes beyond the receive count are discarded and never written.
- R5: A transaction lasts max(transmit count, receive count) bytes. The both-done event (flag bit 4) fires once both buffers are complete. With both counts zero it fires right after the start.
- R6: Transmit-done (bit 2) fires when the last transmit byte is loaded, and receive-done (bit 3) fires when the last receive byte is stored. A direction with a zero count fires its event together with both-done.
- R7: Addresses 10 and 13 hold the number of bytes actually transferred in each direction. Both are cleared when a transaction starts.
- R8: With the chaining bit (address 6, bit 0) set, both-done immediately starts a new transaction.
- R9: The begun event (bit 0) fires when a transaction starts. Stop takes effect at the next byte boundary, or at once when idle or suspended, and then fires the halted event (bit 1).
- R10: Suspend parks SCK low at the next byte boundary with the counters held. Resume continues from the same byte index.
- R11: The SCK half period is 2^k system clocks, where k is the value at address 7.
- R12: Event flags are sticky. Writing the flags register clears each flag whose written bit is 0. The interrupt output is high whenever any flag and its enable bit are both set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regAddr | input | 4 | Register word address |
| regWe | input | 1 | Register write strobe |
| regWdata | input | DW | Register write data |
| regRdata | output | DW | Register read data (combinational on regAddr) |
| memRdEn | output | 1 | Transmit fetch request |
| memRdAddr | output | AW | Transmit fetch address |
| memRdData | input | 8 | Fetched byte, valid one cycle after the request |
| memWrEn | output | 1 | Receive store strobe |
| memWrAddr | output | AW | Receive store address |
| memWrData | output | 8 | Received byte |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| irq | output | 1 | Interrupt request |

## Verification
On every cycle, the assertions check the following:
- memory reads never run past the transmit count, and writes never run past the receive count;
- both-done leaves each amount equal to its maximum count;
- the counters hold while suspended;
- MOSI never moves while SCK is high;
- flags only drop on a write to the flags register.

Other properties can only be shown by the bench's scenarios: the byte values and addresses on the wire and in memory, the fill byte, the SCK period, boundary-timed stop and suspend/resume, chained restarts, the zero-length case and the interrupt mask.

// File: rtl/spim_pkg.sv
package spim_pkg;
  typedef struct packed {
    logic       load;
    logic [7:0] txByte;
  } dpCmd_t;

  typedef struct packed {
    logic       done;
    logic [7:0] rxByte;
  } dpStat_t;

  typedef enum logic [2:0] {
    S_IDLE, S_FETCH, S_LOAD, S_SHIFT, S_STORE, S_PAUSE
  } state_t;

  localparam logic [3:0] A_START  = 4'd0;
  localparam logic [3:0] A_STOP   = 4'd1;
  localparam logic [3:0] A_SUSP   = 4'd2;
  localparam logic [3:0] A_RESUME = 4'd3;
  localparam logic [3:0] A_FLAGS  = 4'd4;
  localparam logic [3:0] A_IRQEN  = 4'd5;
  localparam logic [3:0] A_CHAIN  = 4'd6;
  localparam logic [3:0] A_CLKDIV = 4'd7;
  localparam logic [3:0] A_TXPTR  = 4'd8;
  localparam logic [3:0] A_TXMAX  = 4'd9;
  localparam logic [3:0] A_TXAMT  = 4'd10;
  localparam logic [3:0] A_RXPTR  = 4'd11;
  localparam logic [3:0] A_RXMAX  = 4'd12;
  localparam logic [3:0] A_RXAMT  = 4'd13;
  localparam logic [3:0] A_FILL   = 4'd14;

  localparam int EV_BEGUN = 0;
  localparam int EV_HALT  = 1;
  localparam int EV_TXD   = 2;
  localparam int EV_RXD   = 3;
  localparam int EV_BOTH  = 4;
  localparam int NEV      = 5;
endpackage

// File: rtl/spim_shift.sv
module spim_shift
  import spim_pkg::*;
#(
  parameter int FW = 3
) (
  input  logic          clk,
  input  logic          rstN,
  input  dpCmd_t        cmd,
  input  logic [FW-1:0] freqSel,
  input  logic          miso,
  output logic          sck,
  output logic          mosi,
  output dpStat_t       stat
);
  localparam int DIVW = (1 << FW) - 1;

  logic            busy, done;
  logic [7:0]      txSh, rxSh;
  logic [2:0]      bitCnt;
  logic [DIVW-1:0] divCnt;
  logic [DIVW:0]   halfM1;
  logic            tick;

  assign halfM1 = ((DIVW+1)'(1) << freqSel) - 1'b1;
  assign tick   = ({1'b0, divCnt} == halfM1);
  assign mosi   = txSh[7];
  assign stat.done   = done;
  assign stat.rxByte = rxSh;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy <= 1'b0; sck <= 1'b0; done <= 1'b0;
      txSh <= '0; rxSh <= '0; bitCnt <= '0; divCnt <= '0;
    end else begin
      done <= 1'b0;
      if (cmd.load) begin
        busy <= 1'b1; sck <= 1'b0; txSh <= cmd.txByte;
        bitCnt <= '0; divCnt <= '0;
      end else if (busy) begin
        if (tick) begin
          divCnt <= '0;
          if (!sck) begin
            sck  <= 1'b1;
            rxSh <= {rxSh[6:0], miso};
          end else begin
            sck    <= 1'b0;
            txSh   <= {txSh[6:0], 1'b0};
            bitCnt <= bitCnt + 1'b1;
            if (bitCnt == 3'd7) begin
              busy <= 1'b0;
              done <= 1'b1;
            end
          end
        end else begin
          divCnt <= divCnt + 1'b1;
        end
      end
    end
  end

  // R2: data out is held steady for the whole high phase of SCK
  p_mosi_stable_high_r2: assert property (@(posedge clk) disable iff (!rstN)
    (sck && $past(sck)) |-> $stable(mosi));
  // R2: SCK is low whenever a byte has just completed
  p_sck_low_after_byte_r2: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !sck);
endmodule

// File: rtl/spim_ctrl.sv
module spim_ctrl
  import spim_pkg::*;
#(
  parameter int AW = 16,
  parameter int CW = 8,
  parameter int FW = 3,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [3:0]    regAddr,
  input  logic          regWe,
  input  logic [DW-1:0] regWdata,
  output logic [DW-1:0] regRdata,
  output logic          memRdEn,
  output logic [AW-1:0] memRdAddr,
  input  logic [7:0]    memRdData,
  output logic          memWrEn,
  output logic [AW-1:0] memWrAddr,
  output logic [7:0]    memWrData,
  output logic          irq,
  output logic [FW-1:0] freqSel,
  output dpCmd_t        cmd,
  input  dpStat_t       stat
);
  state_t state, stNext;
  logic [AW-1:0] txPtr, rxPtr, txPtrL, rxPtrL;
  logic [CW-1:0] txMax, rxMax, txMaxL, rxMaxL, txCnt, rxCnt, idx, total;
  logic [7:0]    fillByte;
  logic          chainEn, stopReq, suspReq;
  logic [NEV-1:0] irqEn, flags, ev;
  logic latch, idxInc, txInc, rxInc;
  logic tStart, tStop, tSusp, tResume, flagWr;

  assign tStart  = regWe && regAddr == A_START  && regWdata[0];
  assign tStop   = regWe && regAddr == A_STOP   && regWdata[0];
  assign tSusp   = regWe && regAddr == A_SUSP   && regWdata[0];
  assign tResume = regWe && regAddr == A_RESUME && regWdata[0];
  assign flagWr  = regWe && regAddr == A_FLAGS;

  assign total     = (txMaxL > rxMaxL) ? txMaxL : rxMaxL;
  assign memRdAddr = txPtrL + AW'(idx);
  assign memWrAddr = rxPtrL + AW'(idx);
  assign memWrData = stat.rxByte;
  assign irq       = |(flags & irqEn);

  always_comb begin
    stNext = state; ev = '0; memRdEn = 1'b0; memWrEn = 1'b0;
    cmd = '0; latch = 1'b0; idxInc = 1'b0; txInc = 1'b0; rxInc = 1'b0;
    case (state)
      S_IDLE: begin
        if (tStart) begin
          latch = 1'b1; ev[EV_BEGUN] = 1'b1; stNext = S_FETCH;
        end else if (tStop) ev[EV_HALT] = 1'b1;
      end
      S_FETCH: begin
        if (total == '0) begin
          ev[EV_BOTH] = 1'b1; ev[EV_TXD] = 1'b1; ev[EV_RXD] = 1'b1;
          if (stopReq || tStop) begin
            ev[EV_HALT] = 1'b1; stNext = S_IDLE;
          end else if (chainEn) begin
            latch = 1'b1; ev[EV_BEGUN] = 1'b1;
          end else stNext = S_IDLE;
        end else begin
          memRdEn = idx < txMaxL;
          stNext  = S_LOAD;
        end
      end
      S_LOAD: begin
        cmd.load   = 1'b1;
        cmd.txByte = (idx < txMaxL) ? memRdData : fillByte;
        if (idx < txMaxL) begin
          txInc = 1'b1;
          ev[EV_TXD] = (idx == txMaxL - 1'b1);
        end
        stNext = S_SHIFT;
      end
      S_SHIFT: if (stat.done) stNext = S_STORE;
      S_STORE: begin
        idxInc = 1'b1;
        if (idx < rxMaxL) begin
          memWrEn = 1'b1; rxInc = 1'b1;
          ev[EV_RXD] = (idx == rxMaxL - 1'b1);
        end
        if (idx + 1'b1 == total) begin
          ev[EV_BOTH] = 1'b1;
          if (txMaxL == '0) ev[EV_TXD] = 1'b1;
          if (rxMaxL == '0) ev[EV_RXD] = 1'b1;
        end
        if (stopReq || tStop) begin
          ev[EV_HALT] = 1'b1; stNext = S_IDLE;
        end else if (idx + 1'b1 == total) begin
          if (chainEn) begin
            latch = 1'b1; ev[EV_BEGUN] = 1'b1; stNext = S_FETCH;
          end else stNext = S_IDLE;
        end else if (suspReq || tSusp) stNext = S_PAUSE;
        else stNext = S_FETCH;
      end
      S_PAUSE: begin
        if (tStop) begin
          ev[EV_HALT] = 1'b1; stNext = S_IDLE;
        end else if (tResume) stNext = S_FETCH;
      end
      default: stNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= S_IDLE; txPtr <= '0; rxPtr <= '0; txPtrL <= '0; rxPtrL <= '0;
      txMax <= '0; rxMax <= '0; txMaxL <= '0; rxMaxL <= '0;
      txCnt <= '0; rxCnt <= '0; idx <= '0; fillByte <= '0; freqSel <= '0;
      chainEn <= 1'b0; stopReq <= 1'b0; suspReq <= 1'b0;
      irqEn <= '0; flags <= '0;
    end else begin
      state <= stNext;
      if (regWe) begin
        case (regAddr)
          A_IRQEN:  irqEn    <= regWdata[NEV-1:0];
          A_CHAIN:  chainEn  <= regWdata[0];
          A_CLKDIV: freqSel  <= regWdata[FW-1:0];
          A_TXPTR:  txPtr    <= regWdata[AW-1:0];
          A_TXMAX:  txMax    <= regWdata[CW-1:0];
          A_RXPTR:  rxPtr    <= regWdata[AW-1:0];
          A_RXMAX:  rxMax    <= regWdata[CW-1:0];
          A_FILL:   fillByte <= regWdata[7:0];
          default: ;
        endcase
      end
      flags <= (flagWr ? (flags & regWdata[NEV-1:0]) : flags) | ev;
      if (stNext == S_IDLE || stNext == S_PAUSE) begin
        stopReq <= 1'b0; suspReq <= 1'b0;
      end else begin
        if (tStop && state != S_IDLE) stopReq <= 1'b1;
        if (tSusp && state != S_IDLE) suspReq <= 1'b1;
      end
      if (latch) begin
        txPtrL <= txPtr; rxPtrL <= rxPtr; txMaxL <= txMax; rxMaxL <= rxMax;
        txCnt <= '0; rxCnt <= '0; idx <= '0;
      end else begin
        if (txInc)  txCnt <= txCnt + 1'b1;
        if (rxInc)  rxCnt <= rxCnt + 1'b1;
        if (idxInc) idx   <= idx + 1'b1;
      end
    end
  end

  always_comb begin
    case (regAddr)
      A_FLAGS:  regRdata = DW'(flags);
      A_IRQEN:  regRdata = DW'(irqEn);
      A_CHAIN:  regRdata = DW'(chainEn);
      A_CLKDIV: regRdata = DW'(freqSel);
      A_TXPTR:  regRdata = DW'(txPtr);
      A_TXMAX:  regRdata = DW'(txMax);
      A_TXAMT:  regRdata = DW'(txCnt);
      A_RXPTR:  regRdata = DW'(rxPtr);
      A_RXMAX:  regRdata = DW'(rxMax);
      A_RXAMT:  regRdata = DW'(rxCnt);
      A_FILL:   regRdata = DW'(fillByte);
      default:  regRdata = '0;
    endcase
  end

  // R3: fetches stay inside the transmit buffer
  p_rd_in_tx_r3: assert property (@(posedge clk) disable iff (!rstN)
    memRdEn |-> txCnt < txMaxL);
  // R4: stores stay inside the receive buffer
  p_wr_in_rx_r4: assert property (@(posedge clk) disable iff (!rstN)
    memWrEn |-> rxCnt < rxMaxL);
  // R5: both-done leaves both amounts at their maximum
  p_both_done_r5: assert property (@(posedge clk) disable iff (!rstN)
    (ev[EV_BOTH] && !latch) |=> (txCnt == txMaxL && rxCnt == rxMaxL));
  // R10: counters hold while suspended
  p_pause_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_PAUSE && $past(state) == S_PAUSE) |-> ($stable(txCnt) && $stable(rxCnt)));
  // R12: flags only drop on a flags-register write
  p_flag_sticky_r12: assert property (@(posedge clk) disable iff (!rstN)
    !flagWr |=> ((flags & $past(flags)) == $past(flags)));
endmodule

// File: rtl/spim_dma_top.sv
module spim_dma_top
  import spim_pkg::*;
#(
  parameter int AW = 16,
  parameter int CW = 8,
  parameter int FW = 3,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [3:0]    regAddr,
  input  logic          regWe,
  input  logic [DW-1:0] regWdata,
  output logic [DW-1:0] regRdata,
  output logic          memRdEn,
  output logic [AW-1:0] memRdAddr,
  input  logic [7:0]    memRdData,
  output logic          memWrEn,
  output logic [AW-1:0] memWrAddr,
  output logic [7:0]    memWrData,
  output logic          sck,
  output logic          mosi,
  input  logic          miso,
  output logic          irq
);
  dpCmd_t        cmd;
  dpStat_t       stat;
  logic [FW-1:0] freqSel;

  spim_ctrl #(.AW(AW), .CW(CW), .FW(FW), .DW(DW)) u_ctrl (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWe(regWe),
    .regWdata(regWdata), .regRdata(regRdata),
    .memRdEn(memRdEn), .memRdAddr(memRdAddr), .memRdData(memRdData),
    .memWrEn(memWrEn), .memWrAddr(memWrAddr), .memWrData(memWrData),
    .irq(irq), .freqSel(freqSel), .cmd(cmd), .stat(stat)
  );

  spim_shift #(.FW(FW)) u_shift (
    .clk(clk), .rstN(rstN), .cmd(cmd), .freqSel(freqSel),
    .miso(miso), .sck(sck), .mosi(mosi), .stat(stat)
  );
endmodule

// File: tb/tb_spim_dma_top.sv
module tb_spim_dma_top;
  logic        clk = 1'b0, rstN = 1'b0;
  logic [3:0]  regAddr = '0;
  logic        regWe = 1'b0;
  logic [15:0] regWdata = '0, regRdata;
  logic        memRdEn, memWrEn, sck, mosi, miso, irq;
  logic [15:0] memRdAddr, memWrAddr;
  logic [7:0]  memRdData = '0, memWrData;

  spim_dma_top dut (.*);

  always #5 clk = ~clk;

  int nChk = 0, nFail = 0;
  logic [7:0]  mem [0:255];
  logic [7:0]  mosiQ [$];
  logic [23:0] rxQ [$];
  logic [7:0]  fillVal = 8'h5A;
  int rdSeen = 0, wrSeen = 0, sckRises = 0, cyc = 0, tRise = 0, halfMeas = 0;
  int slvIdx = 0, slvBit = 0, mCnt = 0;
  logic [7:0] mBits = '0;

  always @(posedge clk) memRdData <= mem[memRdAddr[7:0]];
  always @(negedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // slave: MISO carries A0+k, changes after falling SCK
  assign miso = 8'(8'hA0 + slvIdx) >> (7 - slvBit) & 1'b1;
  always @(negedge sck) begin
    if (slvBit == 7) begin slvBit = 0; slvIdx = slvIdx + 1; end
    else slvBit = slvBit + 1;
  end

  // monitor: MOSI bytes vs expected queue (R2, R3)
  always @(posedge sck) begin
    sckRises = sckRises + 1;
    tRise = cyc;
    mBits = {mBits[6:0], mosi};
    mCnt = mCnt + 1;
    if (mCnt == 8) begin
      mCnt = 0;
      if (mosiQ.size() > 0) begin
        logic [7:0] e;
        e = mosiQ.pop_front();
        chk(mBits == e, "R2/R3 mosi byte", mBits, e);
      end
    end
  end
  always @(negedge sck) halfMeas = cyc - tRise;

  // monitor: memory stores vs expected queue (R4)
  always @(negedge clk) begin
    if (memRdEn) rdSeen <= rdSeen + 1;
    if (memWrEn) begin
      wrSeen <= wrSeen + 1;
      if (rxQ.size() > 0) begin
        logic [23:0] e;
        e = rxQ.pop_front();
        chk({memWrAddr, memWrData} == e, "R4 rx store", {memWrAddr, memWrData}, e);
      end else chk(1'b0, "R4 unexpected store", memWrAddr, 0);
    end
  end

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk); regAddr = a; regWdata = d; regWe = 1'b1;
    @(negedge clk); regWe = 1'b0;
  endtask
  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    @(negedge clk); regAddr = a; #1 d = regRdata;
  endtask
  task automatic waitFlag(input int b);
    logic [15:0] v;
    do rd(4'd4, v); while (!v[b]);
  endtask
  task automatic resetSlave();
    slvIdx = 0; slvBit = 0; mCnt = 0;
  endtask

  // driver: push expectations, program buffers, start
  task automatic xfer(input int tp, input int tm, input int rp, input int rm, input bit go);
    int n;
    n = (tm > rm) ? tm : rm;
    for (int i = 0; i < n; i++) begin
      mosiQ.push_back(i < tm ? mem[(tp + i) & 255] : fillVal);
      if (i < rm) rxQ.push_back({16'(rp + i), 8'(8'hA0 + i)});
    end
    resetSlave();
    wr(4'd8, 16'(tp)); wr(4'd9, 16'(tm)); wr(4'd11, 16'(rp)); wr(4'd12, 16'(rm));
    if (go) wr(4'd0, 16'h1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end

  initial begin
    logic [15:0] v;
    int base, r0;
    for (int i = 0; i < 256; i++) mem[i] = 8'(i * 7 + 3);
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // reset state
    rd(4'd4, v);  chk(v == 0, "R12 reset flags", v, 0);
    rd(4'd10, v); chk(v == 0, "R7 reset tx amount", v, 0);
    chk(sck == 0 && irq == 0, "R2 reset sck/irq", {sck, irq}, 0);
    wr(4'd14, 16'(fillVal));

    // R1: zero write to start task does nothing
    r0 = sckRises;
    xfer(16, 2, 100, 2, 0);
    wr(4'd0, 16'h0);
    repeat (40) @(negedge clk);
    rd(4'd4, v); chk(v == 0, "R1 zero write ignored", v, 0);
    chk(sckRises == r0, "R1 no sck", sckRises - r0, 0);
    wr(4'd0, 16'h1);
    waitFlag(4);
    rd(4'd4, v); chk(v == 16'h1D, "R5/R6/R9 flags after equal counts", v, 16'h1D);

    // R3: short transmit, fill byte, one memory read only
    wr(4'd4, 16'h0); base = rdSeen;
    xfer(40, 1, 120, 4, 1);
    waitFlag(4);
    chk(rdSeen - base == 1, "R3 reads limited", rdSeen - base, 1);
    rd(4'd10, v); chk(v == 1, "R7 tx amount", v, 1);
    rd(4'd13, v); chk(v == 4, "R7 rx amount", v, 4);

    // R4: short receive, extra bytes discarded
    wr(4'd4, 16'h0); base = wrSeen;
    xfer(60, 4, 140, 2, 1);
    waitFlag(4);
    repeat (4) @(negedge clk);
    chk(wrSeen - base == 2, "R4 stores limited", wrSeen - base, 2);
    rd(4'd10, v); chk(v == 4, "R7 tx amount 4", v, 4);
    rd(4'd13, v); chk(v == 2, "R7 rx amount 2", v, 2);

    // R11: divider exponent 2 gives 4-clock half period
    wr(4'd4, 16'h0); wr(4'd7, 16'd2);
    xfer(70, 1, 160, 1, 1);
    waitFlag(4);
    chk(halfMeas == 4, "R11 half period", halfMeas, 4);
    wr(4'd7, 16'd0);

    // R5/R6: zero-length transaction
    wr(4'd4, 16'h0); r0 = sckRises;
    xfer(0, 0, 0, 0, 1);
    repeat (6) @(negedge clk);
    rd(4'd4, v); chk(v == 16'h1D, "R5 zero length flags", v, 16'h1D);
    chk(sckRises == r0, "R5 zero length no sck", sckRises - r0, 0);

    // R12: interrupt mask and write-zero clear
    wr(4'd4, 16'h0); wr(4'd5, 16'h10);
    @(negedge clk); chk(irq == 0, "R12 irq low", irq, 0);
    xfer(80, 2, 170, 2, 1);
    waitFlag(4);
    @(negedge clk); chk(irq == 1, "R12 irq high", irq, 1);
    wr(4'd4, 16'h0F);
    rd(4'd4, v); chk(v == 16'h0D, "R12 selective clear", v, 16'h0D);
    chk(irq == 0, "R12 irq cleared", irq, 0);
    wr(4'd5, 16'h0);

    // R10: suspend at byte boundary, resume from same index
    wr(4'd4, 16'h0);
    xfer(90, 4, 180, 4, 1);
    @(negedge clk); while (!memWrEn) @(negedge clk);
    wr(4'd2, 16'h1);
    repeat (60) @(negedge clk);
    rd(4'd13, v); chk(v == 2, "R10 paused rx amount", v, 2);
    rd(4'd10, v); chk(v == 2, "R10 paused tx amount", v, 2);
    r0 = sckRises;
    repeat (50) @(negedge clk);
    chk(sckRises == r0 && sck == 0, "R10 sck parked", sckRises - r0, 0);
    wr(4'd3, 16'h1);
    waitFlag(4);
    rd(4'd13, v); chk(v == 4, "R10 resumed rx amount", v, 4);

    // R9: stop at byte boundary
    wr(4'd4, 16'h0);
    xfer(100, 4, 200, 4, 1);
    @(negedge clk); while (!memWrEn) @(negedge clk);
    wr(4'd1, 16'h1);
    waitFlag(1);
    rd(4'd4, v); chk(v == 16'h03, "R9 halted without both-done", v, 16'h03);
    rd(4'd13, v); chk(v == 2, "R9 stop boundary amount", v, 2);
    mosiQ.delete(); rxQ.delete();

    // R8: chaining restarts without software
    wr(4'd4, 16'h0); wr(4'd6, 16'h1); base = wrSeen;
    resetSlave();
    wr(4'd8, 16'd10); wr(4'd9, 16'd1); wr(4'd11, 16'd210); wr(4'd12, 16'd0);
    wr(4'd0, 16'h1);
    waitFlag(4);
    r0 = sckRises;
    repeat (80) @(negedge clk);
    chk(sckRises - r0 >= 16, "R8 chained restart", sckRises - r0, 16);
    wr(4'd1, 16'h1);
    waitFlag(1);
    wr(4'd6, 16'h0);
    chk(wrSeen == base, "R8 no stores with zero rx", wrSeen - base, 0);

    repeat (5) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end
endmodule